// File: doc/BRIEF.md
# Five-Point Parabolic Step Estimator

The estimator belongs to an iterative search that trims one analog compensation setting. The search measures a signal strength at five settings spaced one step apart: two steps below the current setting, one below, at the setting, one above and two above. It hands those five samples and the step size to this block. The block fits a curvature model to the samples and returns a signed correction that moves the setting toward the model's minimum. If the samples show no positive curvature, the block returns a full step in the direction of the weaker side. The result is always limited to at most one step either way.

A one-cycle `start` pulse captures the inputs. A flat or concave sample set finishes in the following cycle. A convex set launches a restoring shift-subtract divider that runs on unsigned magnitudes for a fixed number of iterations. The sign is restored afterwards. `done` pulses once when the result appears on `corr`, and `corr` then holds its value until the next result replaces it.

Top module: `parab_step_est`

## Requirements
- R1: While reset is asserted and afterwards until the first result, `done` is 0 and `corr` is 0.
- R2: With samples S0..S4 (S0 at two steps below, S4 at two steps above), the block forms the curvature C = 2·(S0 − S2 + S4) − (S1 + S3). When C > 0, the block takes the division path, and `done` rises 22 cycles after the clock edge that accepts `start` (NUM_W + 2, where NUM_W = 20 at the default widths).
- R3: On the division path, the unclamped correction is 7·step·(2·(S0 − S4) + S1 − S3) / (10·C), rounded to the nearest integer, with exact halves rounded away from zero.
- R4: When C ≤ 0, the correction is +step if S0 + S1 > S3 + S4, and −step otherwise (including equality). `done` rises one cycle after the accepting edge.
- R5: The reported correction is clamped to the range −step..+step. `corr` is an 8-bit two's-complement value.
- R6: `done` is high for exactly one cycle per accepted start. Between results, `corr` keeps its last value even when the inputs change.
- R7: A `start` pulse that arrives while a computation is in progress is ignored. It changes neither the pending result nor its timing, and it produces no extra `done`.
- R8: Samples are 8-bit two's complement (−128..127), and step is 7-bit unsigned (0..127). Every combination is handled without overflow. A step of 0 always yields 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that captures the samples and step while idle |
| smp0 | input | 8 | Signed strength at two steps below the setting |
| smp1 | input | 8 | Signed strength at one step below |
| smp2 | input | 8 | Signed strength at the setting |
| smp3 | input | 8 | Signed strength at one step above |
| smp4 | input | 8 | Signed strength at two steps above |
| step | input | 7 | Unsigned step size |
| done | output | 1 | One-cycle pulse when a new correction is on `corr` |
| corr | output | 8 | Signed clamped correction, held until the next result |

## Verification
A fallback result is due one cycle after the edge that accepts `start`. A division result is due 22 cycles after that edge: one edge loads the divider, twenty edges iterate, and one edge rounds and registers the result. The bench drives stimulus and samples outputs on falling clock edges. It counts falling edges from the start pulse to the first observed `done`, so each branch's latency is compared with its exact figure and no check depends on polling luck. It then checks that `corr` and `done` stay quiet for a stretch of cycles after each result, and after a start pulse that arrives while the block is busy.

// File: rtl/parab_pkg.sv
package parab_pkg;

    typedef enum logic {
        EST_IDLE = 1'b0,
        EST_DIV  = 1'b1
    } est_state_e;

endpackage

// File: rtl/est_terms.sv
// Combinational model terms: curvature sign, numerator and denominator magnitudes,
// numerator sign and fallback direction.
module est_terms #(
    parameter int SAMP_W = 8,
    parameter int STEP_W = 7,
    parameter int A_W    = SAMP_W + 4,
    parameter int IN_W   = SAMP_W + 3,
    parameter int NUM_W  = IN_W - 1 + STEP_W + 3,
    parameter int DEN_W  = A_W + 3
) (
    input  logic signed [SAMP_W-1:0] s0,
    input  logic signed [SAMP_W-1:0] s1,
    input  logic signed [SAMP_W-1:0] s2,
    input  logic signed [SAMP_W-1:0] s3,
    input  logic signed [SAMP_W-1:0] s4,
    input  logic        [STEP_W-1:0] step,
    output logic                     curv_pos,
    output logic                     num_neg,
    output logic                     fb_up,
    output logic        [NUM_W-1:0]  num_mag,
    output logic        [DEN_W-1:0]  den_mag
);

    logic signed [A_W-1:0]  e0, e1, e2, e3, e4;
    logic signed [A_W-1:0]  sum_even, curv;
    logic signed [IN_W-1:0] diff_out, slope;
    logic        [IN_W-1:0] slope_mag;

    always_comb begin
        e0 = A_W'(s0);
        e1 = A_W'(s1);
        e2 = A_W'(s2);
        e3 = A_W'(s3);
        e4 = A_W'(s4);

        sum_even = e0 - e2 + e4;
        curv     = sum_even + sum_even - (e1 + e3);
        curv_pos = curv > 0;

        diff_out  = IN_W'(e0) - IN_W'(e4);
        slope     = diff_out + diff_out + IN_W'(e1) - IN_W'(e3);
        num_neg   = slope < 0;
        slope_mag = num_neg ? IN_W'(-slope) : IN_W'(slope);

        num_mag = NUM_W'(slope_mag) * NUM_W'(step) * NUM_W'(7);
        den_mag = DEN_W'(curv) * DEN_W'(10);

        fb_up = (e0 + e1) > (e3 + e4);
    end

endmodule

// File: rtl/est_div.sv
// Restoring shift-subtract divider on unsigned magnitudes, fixed NUM_W iterations.
module est_div #(
    parameter int NUM_W = 20,
    parameter int DEN_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             vld,
    output logic [NUM_W-1:0] quo,
    output logic [DEN_W-1:0] rem,
    output logic [DEN_W-1:0] den_o
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             run;
        logic             vld;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] den;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
    } div_regs_t;

    div_regs_t q_q, q_d;
    logic [DEN_W:0] trial;
    logic           fits;

    always_comb begin
        q_d     = q_q;
        q_d.vld = 1'b0;
        trial   = {q_q.rem, q_q.quo[NUM_W-1]};
        fits    = trial >= {1'b0, q_q.den};

        if (go && !q_q.run) begin
            q_d.run = 1'b1;
            q_d.cnt = CNT_W'(NUM_W);
            q_d.den = den;
            q_d.rem = '0;
            q_d.quo = num;
        end else if (q_q.run) begin
            q_d.rem = fits ? DEN_W'(trial - {1'b0, q_q.den}) : trial[DEN_W-1:0];
            q_d.quo = {q_q.quo[NUM_W-2:0], fits};
            q_d.cnt = q_q.cnt - CNT_W'(1);
            if (q_q.cnt == CNT_W'(1)) begin
                q_d.run = 1'b0;
                q_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign vld   = q_q.vld;
    assign quo   = q_q.quo;
    assign rem   = q_q.rem;
    assign den_o = q_q.den;

endmodule

// File: rtl/est_round_clamp.sv
// Round half away from zero on the magnitude, clamp to step, restore sign.
module est_round_clamp #(
    parameter int NUM_W  = 20,
    parameter int DEN_W  = 15,
    parameter int STEP_W = 7,
    parameter int COR_W  = STEP_W + 1
) (
    input  logic [NUM_W-1:0]        quo,
    input  logic [DEN_W-1:0]        rem,
    input  logic [DEN_W-1:0]        den,
    input  logic [STEP_W-1:0]       step,
    input  logic                    neg,
    output logic signed [COR_W-1:0] corr
);

    logic                    half_up;
    logic [NUM_W:0]          rnd;
    logic [STEP_W-1:0]       mag;
    logic signed [COR_W-1:0] pos;

    always_comb begin
        half_up = {rem, 1'b0} >= {1'b0, den};
        rnd     = {1'b0, quo} + {{NUM_W{1'b0}}, half_up};
        if (rnd > {{(NUM_W + 1 - STEP_W){1'b0}}, step}) mag = step;
        else                                           mag = rnd[STEP_W-1:0];
        pos  = $signed({1'b0, mag});
        corr = neg ? -pos : pos;
    end

endmodule

// File: rtl/parab_step_est.sv
module parab_step_est
    import parab_pkg::*;
#(
    parameter int SAMP_W = 8,
    parameter int STEP_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic signed [SAMP_W-1:0] smp0,
    input  logic signed [SAMP_W-1:0] smp1,
    input  logic signed [SAMP_W-1:0] smp2,
    input  logic signed [SAMP_W-1:0] smp3,
    input  logic signed [SAMP_W-1:0] smp4,
    input  logic        [STEP_W-1:0] step,
    output logic                     done,
    output logic signed [STEP_W:0]   corr
);

    localparam int A_W     = SAMP_W + 4;
    localparam int IN_W    = SAMP_W + 3;
    localparam int NUM_W   = IN_W - 1 + STEP_W + 3;
    localparam int DEN_W   = A_W + 3;
    localparam int COR_W   = STEP_W + 1;
    localparam int LAT_DIV = NUM_W + 2;

    typedef struct packed {
        est_state_e              st;
        logic                    neg;
        logic [STEP_W-1:0]       step;
        logic signed [COR_W-1:0] corr;
        logic                    done;
    } est_regs_t;

    est_regs_t r_q, r_d;

    logic                    curv_pos, num_neg, fb_up;
    logic [NUM_W-1:0]        num_mag, quo;
    logic [DEN_W-1:0]        den_mag, rem, den_used;
    logic                    div_go, div_vld, busy;
    logic signed [COR_W-1:0] div_corr, step_s;

    est_terms #(
        .SAMP_W(SAMP_W), .STEP_W(STEP_W), .A_W(A_W),
        .IN_W(IN_W), .NUM_W(NUM_W), .DEN_W(DEN_W)
    ) u_terms (
        .s0(smp0), .s1(smp1), .s2(smp2), .s3(smp3), .s4(smp4),
        .step(step),
        .curv_pos(curv_pos), .num_neg(num_neg), .fb_up(fb_up),
        .num_mag(num_mag), .den_mag(den_mag)
    );

    est_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go),
        .num(num_mag), .den(den_mag),
        .vld(div_vld), .quo(quo), .rem(rem), .den_o(den_used)
    );

    est_round_clamp #(
        .NUM_W(NUM_W), .DEN_W(DEN_W), .STEP_W(STEP_W), .COR_W(COR_W)
    ) u_rc (
        .quo(quo), .rem(rem), .den(den_used),
        .step(r_q.step), .neg(r_q.neg), .corr(div_corr)
    );

    assign busy   = (r_q.st != EST_IDLE);
    assign div_go = !busy && start && curv_pos;
    assign step_s = $signed({1'b0, step});

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            EST_IDLE: begin
                if (start) begin
                    r_d.step = step;
                    r_d.neg  = num_neg;
                    if (curv_pos) begin
                        r_d.st = EST_DIV;
                    end else begin
                        r_d.corr = fb_up ? step_s : -step_s;
                        r_d.done = 1'b1;
                    end
                end
            end
            EST_DIV: begin
                if (div_vld) begin
                    r_d.corr = div_corr;
                    r_d.done = 1'b1;
                    r_d.st   = EST_IDLE;
                end
            end
            default: r_d.st = EST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= EST_IDLE;
            r_q.neg  <= 1'b0;
            r_q.step <= '0;
            r_q.corr <= '0;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done = r_q.done;
    assign corr = r_q.corr;

endmodule

// File: rtl/parab_step_est_chk.sv
module parab_step_est_chk #(
    parameter int STEP_W  = 7,
    parameter int LAT_DIV = 22
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic [STEP_W-1:0]      step,
    input logic                   done,
    input logic signed [STEP_W:0] corr
);

    localparam int LW = $clog2(LAT_DIV + 2);

    logic [STEP_W-1:0] step_q;
    logic [LW-1:0]     lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
            lat_q  <= '0;
        end else if (start && !busy) begin
            step_q <= step;
            lat_q  <= LW'(1);
        end else if (busy) begin
            lat_q  <= lat_q + LW'(1);
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    corr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(corr));

    // R5
    corr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (corr <= $signed({1'b0, step_q}) && corr >= -$signed({1'b0, step_q})));

    // R2 R4
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == LW'(1) || lat_q == LW'(LAT_DIV)));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> (busy || done));

endmodule

bind parab_step_est parab_step_est_chk #(.STEP_W(STEP_W), .LAT_DIV(LAT_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .step(step), .done(done), .corr(corr)
);

// File: tb/sim_parab_step_est.sv
`timescale 1ns/1ps
module sim_parab_step_est;

    localparam int LAT_D = 22;
    localparam int LAT_F = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic signed [7:0] smp0 = '0, smp1 = '0, smp2 = '0, smp3 = '0, smp4 = '0;
    logic        [6:0] step = '0;
    logic              done;
    logic signed [7:0] corr;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    parab_step_est u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .smp0(smp0), .smp1(smp1), .smp2(smp2), .smp3(smp3), .smp4(smp4),
        .step(step), .done(done), .corr(corr)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic int curv(input int a0, a1, a2, a3, a4);
        return 2 * (a0 - a2 + a4) - (a1 + a3);
    endfunction

    function automatic int model(input int a0, a1, a2, a3, a4, input int st);
        int c, n, d, m, q, r;
        c = curv(a0, a1, a2, a3, a4);
        if (c > 0) begin
            n = 7 * st * (2 * (a0 - a4) + a1 - a3);
            d = 10 * c;
            m = (n < 0) ? -n : n;
            q = (2 * m + d) / (2 * d);
            r = (n < 0) ? -q : q;
        end else begin
            r = (a0 + a1 > a3 + a4) ? st : -st;
        end
        if (r > st) r = st;
        if (r < -st) r = -st;
        return r;
    endfunction

    task automatic run(input int a0, a1, a2, a3, a4, input int st,
                       output int c, output int lat);
        @(negedge clk);
        smp0 = 8'(a0); smp1 = 8'(a1); smp2 = 8'(a2); smp3 = 8'(a3); smp4 = 8'(a4);
        step = 7'(st);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        if (!done) lat = -1;
        c = int'(corr);
    endtask

    task automatic one(input string req, input int a0, a1, a2, a3, a4, input int st);
        int c, lat, exp_lat;
        exp_lat = (curv(a0, a1, a2, a3, a4) > 0) ? LAT_D : LAT_F;
        run(a0, a1, a2, a3, a4, st, c, lat);
        check(req, c, model(a0, a1, a2, a3, a4, st));
        check({req, " latency"}, lat, exp_lat);
    endtask

    task automatic t_reset;
        // R1
        check("R1 done at reset", int'(done), 0);
        check("R1 corr at reset", int'(corr), 0);
    endtask

    task automatic t_rounding;
        // R3 exact halves away from zero, below half down, above half up
        one("R3 tie +0.5", 0, 1, -4, 0, 0, 5);
        one("R3 tie -0.5", 0, 0, -4, 1, 0, 5);
        one("R3 0.4 to 0", 0, 1, -4, 0, 0, 4);
        one("R3 0.6 to 1", 0, 1, -4, 0, 0, 6);
        one("R3 zero slope", 3, 0, -10, 0, 3, 50);
    endtask

    task automatic t_fallback;
        // R4 concave or flat curvature uses the sign test
        one("R4 up", 10, 10, 10, 0, 0, 9);
        one("R4 down", 0, 0, 10, 10, 10, 9);
        one("R4 flat equal", 0, 0, 0, 0, 0, 33);
        one("R4 extreme", -128, -128, 127, 127, 127, 127);
    endtask

    task automatic t_clamp;
        // R5 clamp on both sides
        one("R5 clamp +", 2, 1, 1, 0, 0, 1);
        one("R5 clamp -", 0, 0, 1, 1, 2, 1);
        one("R5 clamp big", 127, 127, -128, -128, -128, 127);
    endtask

    task automatic t_step_sweep;
        // R8 every step value with random samples, both branches
        for (int s = 0; s < 128; s++) begin
            int v[5];
            for (int k = 0; k < 5; k++) v[k] = int'($urandom_range(0, 255)) - 128;
            one((curv(v[0], v[1], v[2], v[3], v[4]) > 0) ? "R8 sweep div" : "R8 sweep fb",
                v[0], v[1], v[2], v[3], v[4], s);
        end
        one("R8 step zero", 100, 0, -50, 0, -20, 0);
    endtask

    task automatic t_random_div;
        // R2 random convex sets, forced positive curvature
        for (int i = 0; i < 60; i++) begin
            int v[5];
            for (int k = 0; k < 5; k++) v[k] = int'($urandom_range(0, 80)) - 40;
            v[2] = -int'($urandom_range(60, 128));
            one("R2 random div", v[0], v[1], v[2], v[3], v[4], int'($urandom_range(1, 127)));
        end
    endtask

    task automatic t_busy_and_hold;
        // R7 second start while busy is ignored; R6 single pulse and hold
        int lat, pulses, held;
        @(negedge clk);
        smp0 = 8'(20); smp1 = 8'(5); smp2 = -8'(30); smp3 = 8'(0); smp4 = 8'(10);
        step = 7'(40);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (3) begin @(negedge clk); lat++; end
        smp0 = 8'(10); smp1 = 8'(10); smp2 = 8'(10); smp3 = 8'(0); smp4 = 8'(0);
        step = 7'(9);
        start = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 60) begin @(negedge clk); lat++; end
        check("R7 result of first start", int'(corr), model(20, 5, -30, 0, 10, 40));
        check("R7 latency unchanged", lat, LAT_D);
        held = int'(corr);
        pulses = 0;
        smp0 = -8'(100); smp4 = 8'(100); step = 7'(120);
        repeat (30) begin
            @(negedge clk);
            if (done) pulses++;
            if (int'(corr) != held) held = 999;
        end
        check("R6 R7 no extra done", pulses, 0);
        check("R6 corr held", held, model(20, 5, -30, 0, 10, 40));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rounding();
        t_fallback();
        t_clamp();
        t_step_sweep();
        t_random_div();
        t_busy_and_hold();
        summary();
        $finish;
    end

endmodule